// File: doc/BRIEF.md
# Time-Slotted Video Memory Arbiter

This block shares one single-port video memory among three clients: the sprite fetch engine, the pattern (layer) fetch engine and the host processor port. It does not use round-robin or priority. It runs a fixed schedule of memory cycles that repeats once per output pixel. Each display engine owns a guaranteed budget of slots in that schedule. The host gets every slot that no display engine has claimed or used.

A pixel strobe input realigns the schedule so that the cycle carrying the strobe is slot 0. Without a strobe the slot index wraps by itself. During blanking the display reservations lapse and every slot is open to the host.

The memory command (enable, write enable, address, write data) is registered, and the grant for that command is shown to its client in the same cycle. Read data from the memory is passed to all clients on one bus. A per-client valid pulse marks the cycle in which the returned word belongs to that client, a fixed latency after its command.

Top module: `vram_slot_arbiter`

## Requirements
- R1: The slot index is 0 in any cycle where `pix_sync` is high. Otherwise it is the previous slot plus one, and it wraps from SLOTS-1 (59) to 0, so with no strobe, slot 60 after a strobe is slot 0 again.
- R2: In slots 0 to 31 (sprite budget), a high `spr_req` wins the slot. One cycle later `gnt_spr` is high and the memory bus shows a read of `spr_addr`.
- R3: In slots 32 to 47 (pattern budget), a high `pat_req` wins the slot. One cycle later `gnt_pat` is high and the memory bus shows a read of `pat_addr`.
- R4: Slots 48 to 59 belong to no display engine. A high `host_req` in such a slot is granted one cycle later, with `mem_we` equal to `host_we`, `mem_addr` equal to `host_addr` and, for a write, `mem_wdata` equal to `host_wdata`.
- R5: A reserved slot whose owner is not requesting goes to a pending host request.
- R6: A display request made in a slot it does not own is ignored. The host never takes a reserved slot that its owner is using.
- R7: While `blank` is high, every slot is open only to the host, and display requests produce no grant.
- R8: A host read yields `rvalid_host` exactly RD_LAT (2) cycles after the cycle in which its command is on the memory bus, with `rd_data` equal to the word returned for that address. No valid pulse arrives one cycle earlier.
- R9: Display reads yield `rvalid_spr` or `rvalid_pat` with the same latency. A host write yields no valid pulse.
- R10: A host request held high while both display engines request in every slot is granted within one pixel period: at slot 48 after a strobe, 49 cycles after the request appears.
- R11: At most one grant is high in any cycle, and `mem_en` is high exactly when one grant is.
- R12: While `rst_n` is low, and after release with no requests, `mem_en`, all grants and all valid pulses are low.
- R13: In the cycle `gnt_host` is high, `host_req` is ignored. A host request held through open slots 48 to 51 is therefore granted in alternate cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_sync | input | 1 | Pixel strobe; marks slot 0 |
| blank | input | 1 | Blanking: all slots open to the host |
| spr_req | input | 1 | Sprite engine read request |
| spr_addr | input | AW (19) | Sprite engine read address |
| pat_req | input | 1 | Pattern engine read request |
| pat_addr | input | AW (19) | Pattern engine read address |
| host_req | input | 1 | Host access request, held until granted |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | AW (19) | Host address |
| host_wdata | input | DW (16) | Host write data |
| mem_en | output | 1 | Memory command valid |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW (19) | Memory address |
| mem_wdata | output | DW (16) | Memory write data |
| mem_rdata | input | DW (16) | Memory read data, RD_LAT cycles after command |
| gnt_spr | output | 1 | Sprite command on the bus this cycle |
| gnt_pat | output | 1 | Pattern command on the bus this cycle |
| gnt_host | output | 1 | Host command on the bus this cycle |
| rvalid_spr | output | 1 | `rd_data` belongs to the sprite engine |
| rvalid_pat | output | 1 | `rd_data` belongs to the pattern engine |
| rvalid_host | output | 1 | `rd_data` belongs to the host |
| rd_data | output | DW (16) | Shared read data |

## Verification
If the slot index were misaligned or wrapped at the wrong count, grants would appear one cycle after a request in a slot that should not carry them. This shows in the very next cycle at any slot border, such as 31/32, 47/48 or 59/60. A wrong latency in the read-valid pipeline would pair `rd_data` with the wrong cycle or the wrong client, and would be seen RD_LAT cycles after the command. A stale host mask or a broken blanking override would show as a missing or doubled `gnt_host` during the first open slot.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_SPR  = 2'd1,
    OWN_PAT  = 2'd2,
    OWN_HOST = 2'd3
  } vram_client_e;
endpackage

// File: rtl/vram_slot_counter.sv
module vram_slot_counter #(
  parameter int SLOTS = 60,
  parameter int SW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_sync,
  output logic [SW-1:0] slot_cur
);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q;
  logic [SW-1:0] slot_d;

  // strobe forces the current cycle to slot 0
  always_comb begin
    slot_cur = pix_sync ? '0 : slot_q;
    slot_d   = (slot_cur == LAST) ? '0 : slot_cur + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST);
endmodule

// File: rtl/vram_slot_policy.sv
module vram_slot_policy
  import vram_arb_pkg::*;
#(
  parameter int SLOTS     = 60,
  parameter int SPR_SLOTS = 32,
  parameter int PAT_SLOTS = 16,
  parameter int SW        = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] slot_cur,
  input  logic          blank,
  input  logic          spr_req,
  input  logic          pat_req,
  input  logic          host_req,
  input  logic          host_hold,
  output vram_client_e  sel
);
  localparam int PAT_END = SPR_SLOTS + PAT_SLOTS;

  logic [SLOTS-1:0] spr_map;
  logic [SLOTS-1:0] pat_map;
  logic             spr_own;
  logic             pat_own;
  logic             host_ok;

  // reservation maps built per slot
  for (genvar g = 0; g < SLOTS; g++) begin : g_map
    if (g < SPR_SLOTS) begin : g_spr
      assign spr_map[g] = 1'b1;
      assign pat_map[g] = 1'b0;
    end else if (g < PAT_END) begin : g_pat
      assign spr_map[g] = 1'b0;
      assign pat_map[g] = 1'b1;
    end else begin : g_free
      assign spr_map[g] = 1'b0;
      assign pat_map[g] = 1'b0;
    end
  end

  always_comb begin
    spr_own = spr_map[slot_cur] & ~blank;
    pat_own = pat_map[slot_cur] & ~blank;
    host_ok = host_req & ~host_hold;
    if (spr_own && spr_req)      sel = OWN_SPR;
    else if (pat_own && pat_req) sel = OWN_PAT;
    else if (host_ok)            sel = OWN_HOST;
    else                         sel = OWN_NONE;
  end

  assert_owner_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == OWN_SPR) |-> (slot_cur < SW'(SPR_SLOTS)));
endmodule

// File: rtl/vram_cmd_stage.sv
module vram_cmd_stage
  import vram_arb_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vram_client_e  sel,
  input  logic [AW-1:0] spr_addr,
  input  logic [AW-1:0] pat_addr,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          gnt_spr,
  output logic          gnt_pat,
  output logic          gnt_host
);
  logic          en_d;
  logic          we_d;
  logic [AW-1:0] addr_d;
  logic [2:0]    gnt_d;

  always_comb begin
    en_d   = (sel != OWN_NONE);
    we_d   = (sel == OWN_HOST) & host_we;
    gnt_d  = {sel == OWN_SPR, sel == OWN_PAT, sel == OWN_HOST};
    unique case (sel)
      OWN_SPR:  addr_d = spr_addr;
      OWN_PAT:  addr_d = pat_addr;
      OWN_HOST: addr_d = host_addr;
      default:  addr_d = mem_addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en   <= 1'b0;
      mem_we   <= 1'b0;
      gnt_spr  <= 1'b0;
      gnt_pat  <= 1'b0;
      gnt_host <= 1'b0;
    end else begin
      mem_en   <= en_d;
      mem_we   <= we_d;
      gnt_spr  <= gnt_d[2];
      gnt_pat  <= gnt_d[1];
      gnt_host <= gnt_d[0];
    end
  end

  // address held when idle, write data loaded only on a write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mem_addr <= '0;
    else if (en_d) mem_addr <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mem_wdata <= '0;
    else if (we_d) mem_wdata <= host_wdata;
  end

  assert_write_host_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && gnt_host));
endmodule

// File: rtl/vram_rd_tracker.sv
module vram_rd_tracker #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_rd,
  input  logic gnt_spr,
  input  logic gnt_pat,
  input  logic gnt_host,
  output logic rvalid_spr,
  output logic rvalid_pat,
  output logic rvalid_host
);
  logic [2:0] stage_q [RD_LAT];
  logic [2:0] stage_d [RD_LAT];

  always_comb begin
    stage_d[0] = {gnt_spr, gnt_pat, gnt_host} & {3{cmd_rd}};
    for (int i = 1; i < RD_LAT; i++) stage_d[i] = stage_q[i-1];
  end

  for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign {rvalid_spr, rvalid_pat, rvalid_host} = stage_q[RD_LAT-1];

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rvalid_spr, rvalid_pat, rvalid_host}));
endmodule

// File: rtl/vram_slot_arbiter.sv
module vram_slot_arbiter
  import vram_arb_pkg::*;
#(
  parameter int SLOTS     = 60,
  parameter int SPR_SLOTS = 32,
  parameter int PAT_SLOTS = 16,
  parameter int AW        = 19,
  parameter int DW        = 16,
  parameter int RD_LAT    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_sync,
  input  logic          blank,
  input  logic          spr_req,
  input  logic [AW-1:0] spr_addr,
  input  logic          pat_req,
  input  logic [AW-1:0] pat_addr,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          gnt_spr,
  output logic          gnt_pat,
  output logic          gnt_host,
  output logic          rvalid_spr,
  output logic          rvalid_pat,
  output logic          rvalid_host,
  output logic [DW-1:0] rd_data
);
  localparam int SW = $clog2(SLOTS);
  localparam int WW = $clog2(SLOTS + 2);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q;
  logic rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [SW-1:0] slot_cur;
  vram_client_e  sel;

  vram_slot_counter #(.SLOTS(SLOTS), .SW(SW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .pix_sync (pix_sync),
    .slot_cur (slot_cur)
  );

  vram_slot_policy #(
    .SLOTS(SLOTS), .SPR_SLOTS(SPR_SLOTS), .PAT_SLOTS(PAT_SLOTS), .SW(SW)
  ) u_pol (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .slot_cur  (slot_cur),
    .blank     (blank),
    .spr_req   (spr_req),
    .pat_req   (pat_req),
    .host_req  (host_req),
    .host_hold (gnt_host),
    .sel       (sel)
  );

  vram_cmd_stage #(.AW(AW), .DW(DW)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .sel        (sel),
    .spr_addr   (spr_addr),
    .pat_addr   (pat_addr),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .gnt_spr    (gnt_spr),
    .gnt_pat    (gnt_pat),
    .gnt_host   (gnt_host)
  );

  vram_rd_tracker #(.RD_LAT(RD_LAT)) u_rd (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .cmd_rd      (mem_en & ~mem_we),
    .gnt_spr     (gnt_spr),
    .gnt_pat     (gnt_pat),
    .gnt_host    (gnt_host),
    .rvalid_spr  (rvalid_spr),
    .rvalid_pat  (rvalid_pat),
    .rvalid_host (rvalid_host)
  );

  assign rd_data = mem_rdata;

  // host wait tracker for the bound check
  logic [WW-1:0] wait_q;
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)                 wait_q <= '0;
    else if (!host_req || gnt_host)  wait_q <= '0;
    else if (wait_q != WW'(SLOTS+1)) wait_q <= wait_q + 1'b1;
  end

  assert_host_wait_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    wait_q <= WW'(SLOTS));

  assert_one_grant_R11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0({gnt_spr, gnt_pat, gnt_host}) && (mem_en == (gnt_spr | gnt_pat | gnt_host)));

  assert_spr_req_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    gnt_spr |-> $past(spr_req));

  assert_pat_req_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    gnt_pat |-> $past(pat_req));

  assert_blank_host_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ($past(blank) && mem_en) |-> gnt_host);

  assert_no_back_to_back_R13: assert property (@(posedge clk) disable iff (!rst_sync_q)
    gnt_host |=> !gnt_host);
endmodule

// File: tb/sim_vram_slot_arbiter.sv
module sim_vram_slot_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 16;
  localparam int RD_LAT = 2;
  localparam logic [AW-1:0] SPR_A  = 19'h11111;
  localparam logic [AW-1:0] PAT_A  = 19'h22222;
  localparam logic [AW-1:0] HOST_A = 19'h33333;
  localparam logic [DW-1:0] HOST_D = 16'hBEEF;

  logic clk = 1'b0;
  logic rst_n;
  logic pix_sync, blank, spr_req, pat_req, host_req, host_we;
  logic [AW-1:0] spr_addr, pat_addr, host_addr;
  logic [DW-1:0] host_wdata, mem_rdata, mem_wdata, rd_data;
  logic mem_en, mem_we, gnt_spr, gnt_pat, gnt_host;
  logic rvalid_spr, rvalid_pat, rvalid_host;
  logic [AW-1:0] mem_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_slot_arbiter #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_sync(pix_sync), .blank(blank),
    .spr_req(spr_req), .spr_addr(spr_addr), .pat_req(pat_req), .pat_addr(pat_addr),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .gnt_spr(gnt_spr), .gnt_pat(gnt_pat), .gnt_host(gnt_host),
    .rvalid_spr(rvalid_spr), .rvalid_pat(rvalid_pat), .rvalid_host(rvalid_host),
    .rd_data(rd_data)
  );

  // memory model: word derived from address, returned RD_LAT cycles later
  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return a[DW-1:0] ^ 16'hA5C3;
  endfunction

  logic [DW-1:0] mq [RD_LAT];
  always @(posedge clk) begin
    mq[0] <= mem_word(mem_addr);
    for (int i = 1; i < RD_LAT; i++) mq[i] <= mq[i-1];
  end
  assign mem_rdata = mq[RD_LAT-1];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    pix_sync = 0; blank = 0; spr_req = 0; pat_req = 0; host_req = 0; host_we = 0;
  endtask

  // strobe slot 0, then present the requests for one cycle in the target slot;
  // returns at the falling edge where the registered result is visible
  task automatic run_slot(input int slot, input logic b, input logic s,
                          input logic p, input logic h, input logic w);
    @(negedge clk); clear_in();
    @(negedge clk);
    pix_sync = 1; blank = b;
    if (slot == 0) begin spr_req = s; pat_req = p; host_req = h; host_we = w; end
    for (int k = 1; k <= slot; k++) begin
      @(negedge clk);
      pix_sync = 0;
      if (k == slot) begin spr_req = s; pat_req = p; host_req = h; host_we = w; end
    end
    @(negedge clk); clear_in();
  endtask

  // vector: [13:8] slot, 7 blank, 6 spr, 5 pat, 4 host, 3 we, [2:0] expected {spr,pat,host}
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b100},  // R2
    {6'd31, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b100},  // R2 R6
    {6'd32, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b010},  // R3 R6
    {6'd47, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b010},  // R3
    {6'd48, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b000},  // R6
    {6'd48, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001},  // R4
    {6'd59, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b001},  // R4 R6
    {6'd10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001},  // R5
    {6'd40, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'b001},  // R5
    {6'd5,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 3'b001},  // R7
    {6'd20, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000},  // R7
    {6'd60, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'b100},  // R1 wrap
    {6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000}   // R11 idle
  };
  localparam int VREQ [NV] = '{2, 6, 3, 3, 6, 4, 4, 5, 5, 7, 7, 1, 11};

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0;
    clear_in();
    spr_addr = SPR_A; pat_addr = PAT_A; host_addr = HOST_A; host_wdata = HOST_D;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({mem_en, gnt_spr, gnt_pat, gnt_host, rvalid_spr, rvalid_pat, rvalid_host} == 7'd0,
        "R12 outputs in reset", {mem_en, gnt_spr, gnt_pat, gnt_host}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk({mem_en, gnt_spr, gnt_pat, gnt_host, rvalid_spr, rvalid_pat, rvalid_host} == 7'd0,
        "R12 idle after reset", {mem_en, gnt_spr, gnt_pat, gnt_host}, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [2:0] exp_g;
      logic [AW-1:0] exp_a;
      exp_g = VEC[v][2:0];
      run_slot(int'(VEC[v][13:8]), VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4], VEC[v][3]);
      chk({gnt_spr, gnt_pat, gnt_host} == exp_g, $sformatf("R%0d grant vec %0d", VREQ[v], v),
          {gnt_spr, gnt_pat, gnt_host}, exp_g);
      chk(mem_en == (exp_g != 0), $sformatf("R11 mem_en vec %0d", v), mem_en, exp_g != 0);
      if (exp_g != 0) begin
        exp_a = exp_g[2] ? SPR_A : (exp_g[1] ? PAT_A : HOST_A);
        chk(mem_addr == exp_a, $sformatf("R%0d address vec %0d", VREQ[v], v), mem_addr, exp_a);
        chk(mem_we == (exp_g[0] & VEC[v][3]), $sformatf("R%0d write enable vec %0d", VREQ[v], v),
            mem_we, exp_g[0] & VEC[v][3]);
        if (mem_we) chk(mem_wdata == HOST_D, "R4 write data", mem_wdata, HOST_D);
      end
    end

    // R8 host read latency and data
    run_slot(50, 0, 0, 0, 1, 0);
    chk(gnt_host && !mem_we, "R8 host read command", {gnt_host, mem_we}, 2'b10);
    repeat (RD_LAT - 1) @(negedge clk);
    chk(!rvalid_host, "R8 no early valid", rvalid_host, 0);
    @(negedge clk);
    chk(rvalid_host && !rvalid_spr && !rvalid_pat, "R8 host valid",
        {rvalid_spr, rvalid_pat, rvalid_host}, 3'b001);
    chk(rd_data == mem_word(HOST_A), "R8 host read data", rd_data, mem_word(HOST_A));

    // R9 sprite read latency
    run_slot(3, 0, 1, 0, 0, 0);
    repeat (RD_LAT) @(negedge clk);
    chk({rvalid_spr, rvalid_pat, rvalid_host} == 3'b100, "R9 sprite valid",
        {rvalid_spr, rvalid_pat, rvalid_host}, 3'b100);
    chk(rd_data == mem_word(SPR_A), "R9 sprite read data", rd_data, mem_word(SPR_A));

    // R9 pattern read latency
    run_slot(33, 0, 0, 1, 0, 0);
    repeat (RD_LAT) @(negedge clk);
    chk({rvalid_spr, rvalid_pat, rvalid_host} == 3'b010, "R9 pattern valid",
        {rvalid_spr, rvalid_pat, rvalid_host}, 3'b010);

    // R9 host write gives no valid
    run_slot(55, 0, 0, 0, 1, 1);
    chk(gnt_host && mem_we, "R9 host write issued", {gnt_host, mem_we}, 2'b11);
    repeat (RD_LAT) @(negedge clk);
    chk({rvalid_spr, rvalid_pat, rvalid_host} == 3'b000, "R9 no valid for write",
        {rvalid_spr, rvalid_pat, rvalid_host}, 0);

    // R10 host waits behind fully busy display engines
    begin
      int first;
      first = -1;
      @(negedge clk); clear_in();
      @(negedge clk);
      pix_sync = 1; spr_req = 1; pat_req = 1; host_req = 1; host_we = 0;
      for (int k = 1; k <= 60; k++) begin
        @(negedge clk);
        pix_sync = 0;
        if (gnt_host && first < 0) begin first = k; host_req = 0; end
      end
      clear_in();
      chk(first == 49, "R10 host grant delay", first, 49);
    end

    // R13 held host request in open slots 48..51 alternates
    begin
      logic [3:0] seen;
      seen = '0;
      @(negedge clk); clear_in();
      @(negedge clk); pix_sync = 1;
      for (int k = 1; k <= 48; k++) begin
        @(negedge clk); pix_sync = 0;
        if (k == 48) host_req = 1;
      end
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        seen[3-k] = gnt_host;
      end
      clear_in();
      chk(seen == 4'b1010, "R13 alternate grants", seen, 4'b1010);
    end

    // R1 strobe realigns mid-period: strobe at arbitrary point makes that cycle slot 0
    run_slot(0, 0, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    run_slot(31, 0, 1, 0, 0, 0);
    chk(gnt_spr, "R1 realign slot 31", gnt_spr, 1);

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule